// File: doc/BRIEF.md
# Microprogrammed Single-Bus Processor Core

This block is a small processor in which a microcode sequencer drives a datapath built around one shared bus. Each clock cycle, the current microstate selects at most one source and one destination for the bus. The bus can connect the program counter, the memory address register, the instruction register, the two ALU operand registers, an eight-entry register file, the zero flag and the memory read-data port. The control store is made of two tables indexed by microstate number: one gives the bus action, the other gives the successor state. The successor can also come from an opcode dispatch or from a test of the zero flag.

Four instruction kinds are carried out: add, branch-if-equal, no-operation and, for every other opcode, a permanent stop with a status flag raised. Memory is read-only from the core's side and may be slow. A parameter inserts a fixed number of idle microstates between loading the address register and capturing the instruction word, and every fetch uses the same number.

Top module: `ucode_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mem_addr` becomes 0, `halt_illegal` becomes low, the program counter and both operand registers clear, and register k of the file is loaded with the value k. Execution then starts with a fetch from address 0.
- R2: The first cycle of each instruction copies the program counter into the address register, so `mem_addr` shows the instruction's address from the next edge on. Fetch plus decode take WAIT_STATES+3 cycles, and `mem_addr` holds its value until the next instruction's first cycle.
- R3: Opcode 0000 (bits 31:28) adds register RA (bits 26:24) to register RB (bits 22:20) and writes the sum to RB. It takes 6 cycles after decode and then continues at the program counter plus 1.
- R4: Opcode 0100 with equal RA and RB contents loads the program counter with the program counter plus the sign-extended 16-bit offset in bits 15:0. It takes 7 cycles after decode and applies no extra increment.
- R5: Opcode 0100 with unequal RA and RB contents takes 7 cycles after decode and continues at the program counter plus 1.
- R6: Opcode 0111 takes 3 cycles after decode and continues at the program counter plus 1.
- R7: Any other opcode raises `halt_illegal` in the cycle after decode. The flag stays high, and `mem_addr` stays frozen, until reset.
- R8: The instruction word is captured exactly WAIT_STATES+1 cycles after the address register is loaded. Read data presented earlier than that has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | DATA_W | Memory address, the address register's contents |
| mem_rdata | input | DATA_W | Memory read data, sampled when the instruction register loads |
| halt_illegal | output | 1 | High once an unimplemented opcode has been decoded |

## Verification
Four programs are run, each from reset. A cycle-accurate model in the bench predicts `mem_addr` and `halt_illegal` on every clock. The first program mixes adds, a taken and a not-taken branch, a no-operation and a backward branch that loops. This separates correct register updates from stale ones, because the second pass through the loop must take the opposite branch. The second program branches on a value that only matches if reset has restored the register file. The third branches to itself with a zero offset, which tells an extra increment apart from none. The fourth branches with the most negative offset, which exposes a missing sign extension in the upper address bits. During each wait window the bench memory returns an illegal opcode, so capturing the instruction one cycle early halts the core and is caught.

// File: rtl/ucpu_pkg.sv
// Package: shared types and control-store contents for the microcoded core.
// Assumes a 6-bit microstate space; idle fetch states occupy states 3..9.
package ucpu_pkg;

    typedef logic [5:0] ustate_t;

    localparam ustate_t US_FETCH    = 6'd0;
    localparam ustate_t US_LOADIR   = 6'd1;
    localparam ustate_t US_DISPATCH = 6'd2;
    localparam ustate_t US_WAIT0    = 6'd3;
    localparam ustate_t US_ADD0     = 6'd17;
    localparam ustate_t US_BEQ0     = 6'd20;
    localparam ustate_t US_BEQTEST  = 6'd23;
    localparam ustate_t US_BR0      = 6'd24;
    localparam ustate_t US_INC0     = 6'd57;
    localparam ustate_t US_HALT     = 6'd63;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_PC, SRC_MEM, SRC_RA, SRC_RB, SRC_ALU, SRC_OFFS, SRC_ONE
    } bus_src_e;

    typedef enum logic [2:0] {
        DST_NONE, DST_MAR, DST_IR, DST_A, DST_B, DST_Z, DST_PC, DST_RB
    } bus_dst_e;

    typedef enum logic [1:0] {
        NX_SEQ, NX_DISPATCH, NX_ZTEST
    } nx_mode_e;

    typedef struct packed {
        bus_src_e src;
        bus_dst_e dst;
        logic     alu_sub;
        nx_mode_e mode;
        ustate_t  next;
    } uword_t;

    // Opcode dispatch table used in the decode state.
    function automatic ustate_t dispatch_target(input logic [3:0] op);
        case (op)
            4'b0000: return US_ADD0;
            4'b0100: return US_BEQ0;
            4'b0111: return US_INC0;
            default: return US_HALT;
        endcase
    endfunction

    // Control-store word for microstate s, given the number of idle fetch states.
    function automatic uword_t urom_entry(input int unsigned s, input int unsigned waits);
        uword_t w;
        w.src     = SRC_NONE;
        w.dst     = DST_NONE;
        w.alu_sub = 1'b0;
        w.mode    = NX_SEQ;
        w.next    = US_HALT;
        if (s >= 3 && s < 3 + waits) begin
            w.next = (s == 3 + waits - 1) ? US_LOADIR : ustate_t'(s + 1);
        end else begin
            case (s)
                0:  begin w.src = SRC_PC;  w.dst = DST_MAR;
                          w.next = (waits == 0) ? US_LOADIR : US_WAIT0; end
                1:  begin w.src = SRC_MEM; w.dst = DST_IR; w.next = US_DISPATCH; end
                2:  begin w.mode = NX_DISPATCH; end
                17: begin w.src = SRC_RA;  w.dst = DST_A;  w.next = 6'd18; end
                18: begin w.src = SRC_RB;  w.dst = DST_B;  w.next = 6'd19; end
                19: begin w.src = SRC_ALU; w.dst = DST_RB; w.next = US_INC0; end
                20: begin w.src = SRC_RA;  w.dst = DST_A;  w.next = 6'd21; end
                21: begin w.src = SRC_RB;  w.dst = DST_B;  w.next = 6'd22; end
                22: begin w.src = SRC_ALU; w.dst = DST_Z;  w.alu_sub = 1'b1;
                          w.next = US_BEQTEST; end
                23: begin w.mode = NX_ZTEST; w.next = US_INC0; end
                24: begin w.src = SRC_PC;   w.dst = DST_A;  w.next = 6'd25; end
                25: begin w.src = SRC_OFFS; w.dst = DST_B;  w.next = 6'd26; end
                26: begin w.src = SRC_ALU;  w.dst = DST_PC; w.next = US_FETCH; end
                57: begin w.src = SRC_PC;   w.dst = DST_A;  w.next = 6'd58; end
                58: begin w.src = SRC_ONE;  w.dst = DST_B;  w.next = 6'd59; end
                59: begin w.src = SRC_ALU;  w.dst = DST_PC; w.next = US_FETCH; end
                default: begin w.next = US_HALT; end
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/ucpu_regfile.sv
// Register file: NREG words, two combinational read ports, one write port.
// Assumes reset loads each entry with its own index so programs have operands.
module ucpu_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data
);

    logic [DW-1:0] regs_q [NREG];

    // Storage: reset to index values, otherwise single-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                regs_q[k] <= DW'(k);
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = regs_q[rd_a_idx];
    assign rd_b_data = regs_q[rd_b_idx];

endmodule

// File: rtl/ucpu_useq.sv
// Microsequencer: holds the microstate, reads the control store and selects the
// successor from the stored link, the opcode dispatch or the zero-flag test.
// Assumes WAITS is in 0..7 so idle states stay below the add sequence.
module ucpu_useq
    import ucpu_pkg::*;
#(
    parameter int WAITS = 3,
    localparam int NSTATE = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] opcode,
    input  logic       z_flag,
    output bus_src_e   bus_src,
    output bus_dst_e   bus_dst,
    output logic       alu_sub,
    output logic       halted
);

    ustate_t state_q;
    ustate_t state_d;
    uword_t  rom [NSTATE];
    uword_t  cur;

    for (genvar g = 0; g < NSTATE; g++) begin : g_rom
        assign rom[g] = urom_entry(g, WAITS);
    end

    assign cur = rom[state_q];

    // Successor selection from the current word's mode.
    always_comb begin
        case (cur.mode)
            NX_DISPATCH: state_d = dispatch_target(opcode);
            NX_ZTEST:    state_d = z_flag ? US_BR0 : cur.next;
            default:     state_d = cur.next;
        endcase
    end

    // Microstate register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= US_FETCH;
        else        state_q <= state_d;
    end

    assign bus_src = cur.src;
    assign bus_dst = cur.dst;
    assign alu_sub = cur.alu_sub;
    assign halted  = (state_q == US_HALT);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == US_HALT) |=> (state_q == US_HALT));

    // R6
    noop_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == US_DISPATCH && opcode == 4'b0111) |=> (state_q == US_INC0));

    // R4
    beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == US_BEQTEST && z_flag) |=> (state_q == US_BR0));

endmodule

// File: rtl/ucpu_datapath.sv
// Single-bus datapath: PC, MAR, IR, operand registers, zero flag, ALU and the
// register file, all joined by one bus driven by exactly one selected source.
// Assumes field positions given by the RA_LSB/RB_LSB parameters and a top opcode nibble.
module ucpu_datapath
    import ucpu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NREG   = 8,
    parameter int OFFS_W = 16,
    parameter int RA_LSB = 24,
    parameter int RB_LSB = 20,
    localparam int IW    = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_src_e      bus_src,
    input  bus_dst_e      bus_dst,
    input  logic          alu_sub,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_addr,
    output logic [3:0]    opcode,
    output logic          z_flag
);

    logic [DW-1:0] pc_q, mar_q, ir_q, a_q, b_q;
    logic          z_q;
    logic [DW-1:0] bus;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] offs_ext;
    logic [DW-1:0] ra_data, rb_data;
    logic [IW-1:0] ra_idx, rb_idx;

    assign ra_idx   = ir_q[RA_LSB +: IW];
    assign rb_idx   = ir_q[RB_LSB +: IW];
    assign offs_ext = {{(DW-OFFS_W){ir_q[OFFS_W-1]}}, ir_q[OFFS_W-1:0]};
    assign alu_res  = alu_sub ? (a_q - b_q) : (a_q + b_q);

    ucpu_regfile #(.DW(DW), .NREG(NREG)) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ra_idx),
        .rd_b_idx  (rb_idx),
        .wr_en     (bus_dst == DST_RB),
        .wr_idx    (rb_idx),
        .wr_data   (bus),
        .rd_a_data (ra_data),
        .rd_b_data (rb_data)
    );

    // Bus source multiplexer.
    always_comb begin
        case (bus_src)
            SRC_PC:   bus = pc_q;
            SRC_MEM:  bus = mem_rdata;
            SRC_RA:   bus = ra_data;
            SRC_RB:   bus = rb_data;
            SRC_ALU:  bus = alu_res;
            SRC_OFFS: bus = offs_ext;
            SRC_ONE:  bus = DW'(1);
            default:  bus = '0;
        endcase
    end

    // Bus destination registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            z_q   <= 1'b0;
        end else begin
            case (bus_dst)
                DST_MAR: mar_q <= bus;
                DST_IR:  ir_q  <= bus;
                DST_A:   a_q   <= bus;
                DST_B:   b_q   <= bus;
                DST_Z:   z_q   <= (bus == '0);
                DST_PC:  pc_q  <= bus;
                default: ;
            endcase
        end
    end

    assign mem_addr = mar_q;
    assign opcode   = ir_q[DW-1 -: 4];
    assign z_flag   = z_q;

    // R2
    mar_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mar_q) |-> ($past(bus_dst) == DST_MAR));

    // R4
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_q) |-> ($past(bus_dst) == DST_PC));

    // R5
    z_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(z_q) |-> ($past(bus_dst) == DST_Z));

endmodule

// File: rtl/ucode_cpu.sv
// Top: microprogrammed single-bus core. Connects the sequencer to the datapath.
// Assumes a memory that answers within WAIT_STATES+1 cycles of an address change.
module ucode_cpu #(
    parameter int DATA_W      = 32,
    parameter int NUM_REGS    = 8,
    parameter int OFFSET_W    = 16,
    parameter int WAIT_STATES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halt_illegal
);

    ucpu_pkg::bus_src_e bus_src;
    ucpu_pkg::bus_dst_e bus_dst;
    logic               alu_sub;
    logic [3:0]         opcode;
    logic               z_flag;

    ucpu_useq #(.WAITS(WAIT_STATES)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .z_flag  (z_flag),
        .bus_src (bus_src),
        .bus_dst (bus_dst),
        .alu_sub (alu_sub),
        .halted  (halt_illegal)
    );

    ucpu_datapath #(
        .DW     (DATA_W),
        .NREG   (NUM_REGS),
        .OFFS_W (OFFSET_W)
    ) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_src   (bus_src),
        .bus_dst   (bus_dst),
        .alu_sub   (alu_sub),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .opcode    (opcode),
        .z_flag    (z_flag)
    );

endmodule

// File: tb/ucode_cpu_tb_top.sv
// Bench: behavioural instruction model expanded to a per-cycle trace of
// mem_addr and halt_illegal, compared on every falling clock edge.
module ucode_cpu_tb_top;

    localparam int WAITS = 3;
    localparam int DW    = 32;
    localparam logic [31:0] JUNK = 32'hF000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mem_rdata = JUNK;
    logic [DW-1:0] mem_addr;
    logic          halt_illegal;

    ucode_cpu #(.DATA_W(DW), .NUM_REGS(8), .OFFSET_W(16), .WAIT_STATES(WAITS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .halt_illegal (halt_illegal)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mem [64];
    logic [31:0] q_addr [$];
    bit          q_halt [$];
    string       q_tag  [$];

    function automatic logic [31:0] enc(int op, int ra, int rb, int off);
        return {op[3:0], 1'b0, ra[2:0], 1'b0, rb[2:0], 4'b0000, off[15:0]};
    endfunction

    function automatic logic [31:0] rd(logic [31:0] a);
        return (a < 64) ? mem[a[5:0]] : 32'h0;
    endfunction

    // Slow memory: junk until the address has been steady WAITS cycles (R8).
    logic [31:0] last_addr = '0;
    int          age = 0;
    always @(negedge clk) begin
        if (mem_addr !== last_addr) age = 0;
        else if (age < 1000) age = age + 1;
        last_addr = mem_addr;
        mem_rdata = (age >= WAITS) ? rd(mem_addr) : JUNK;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(logic [31:0] a, bit h, string t);
        q_addr.push_back(a);
        q_halt.push_back(h);
        q_tag.push_back(t);
    endtask

    // Instruction-level model expanded into per-cycle expectations.
    task automatic build_model(int n);
        logic [31:0] pc, iw, offx;
        logic [31:0] r [8];
        bit halted;
        int op, ra, rb;
        q_addr.delete(); q_halt.delete(); q_tag.delete();
        pc = 0; halted = 0;
        for (int k = 0; k < 8; k++) r[k] = k;
        while (q_addr.size() < n) begin
            if (halted) begin
                push(pc, 1'b1, "R7");
            end else begin
                iw = rd(pc);
                op = int'(iw[31:28]);
                ra = int'(iw[26:24]);
                rb = int'(iw[22:20]);
                offx = {{16{iw[15]}}, iw[15:0]};
                if (op != 0 && op != 4 && op != 7) begin
                    repeat (WAITS + 2) push(pc, 1'b0, "R2 R8");
                    halted = 1;
                end else begin
                    repeat (WAITS + 3) push(pc, 1'b0, "R2 R8");
                    if (op == 0) begin
                        repeat (6) push(pc, 1'b0, "R3");
                        r[rb] = r[ra] + r[rb];
                        pc = pc + 1;
                    end else if (op == 4) begin
                        if (r[ra] == r[rb]) begin
                            repeat (7) push(pc, 1'b0, "R4");
                            pc = pc + offx;
                        end else begin
                            repeat (7) push(pc, 1'b0, "R5");
                            pc = pc + 1;
                        end
                    end else begin
                        repeat (3) push(pc, 1'b0, "R6");
                        pc = pc + 1;
                    end
                end
            end
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 64; k++) mem[k] = JUNK;
    endtask

    task automatic run_prog(int n);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_addr == 32'h0, "R1 reset address", mem_addr, 32'h0);
        check(halt_illegal == 1'b0, "R1 reset halt", {31'b0, halt_illegal}, 32'h0);
        build_model(n);
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(mem_addr == q_addr[i], q_tag[i], mem_addr, q_addr[i]);
            check(halt_illegal == q_halt[i], q_tag[i], {31'b0, halt_illegal},
                  {31'b0, q_halt[i]});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: cycles actual %0d expected below %0d", 20000, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Program A: adds, taken/not-taken branches, no-op, backward loop, stop.
        clear_mem();
        mem[0] = enc(0, 1, 2, 0);
        mem[1] = enc(4, 2, 3, 5);
        mem[2] = enc(2, 0, 0, 0);
        mem[6] = enc(7, 0, 0, 0);
        mem[7] = enc(4, 1, 2, 9);
        mem[8] = enc(4, 0, 0, -8);
        run_prog(130);

        // Program B: equality only if reset restored the file (R1), then stop.
        clear_mem();
        mem[0]  = enc(0, 1, 1, 0);
        mem[1]  = enc(4, 1, 2, 10);
        mem[11] = enc(6, 0, 0, 0);
        run_prog(50);

        // Program C: branch to self with zero offset (R4, no extra increment).
        clear_mem();
        mem[0] = enc(7, 0, 0, 0);
        mem[1] = enc(4, 7, 7, 0);
        run_prog(80);

        // Program D: most negative offset, sign extension reaches the top bits.
        clear_mem();
        mem[0] = enc(4, 5, 5, -32768);
        run_prog(60);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule